// File: doc/BRIEF.md
# Fan PWM Generator with Override and Settling

This block drives a cooling fan's PWM pin. The waveform's period and high time are both counted in clock cycles. The period is a fixed parameter. At the default of 20000 cycles and a 100 MHz clock, the output runs at 5 kHz. The high time, called the active width, comes from one of two places:

- a coarse duty level chosen by the temperature logic beside this block;
- a software request for an exact width, accepted only if it falls inside a safe range.

A new width is loaded only when one period ends and the next begins, so the pin never shows a shortened pulse.

Whenever the requested width changes, a long settle timer starts and fan-speed (tacho) supervision is switched off until the timer ends. When the timer ends, a one-cycle change-done pulse is raised. If hardware made the change, supervision comes back at that moment. If software made the change, supervision returns only after software writes new tacho parameters: a period first, then a tolerance. If the hardware level later climbs above the software width, the hardware width takes over again and a fresh settle window starts.

Top module: `fanpwm_core`

## Requirements
- R1: During and right after reset, the active width equals PERIOD (100%), `monitor_en` and `change_done` are low, and a settle window starts at reset release.
- R2: The `hw_duty` code maps to a width as follows: 1 gives PERIOD/4, 2 gives PERIOD/2, 3 gives 3*PERIOD/4, and 4 to 7 give PERIOD. Over any window of PERIOD cycles at a steady width, `pwm` is high for exactly that many cycles.
- R3: `hw_duty` code 0 gives width 0, so `pwm` stays low. A width of PERIOD keeps `pwm` constantly high.
- R4: A software request with a `sw_width_we` strobe is accepted when the current hardware width is no greater than the request and the request is no greater than PERIOD. It then becomes the active width. A later drop of the hardware level leaves it in place.
- R5: A software request below the hardware width, or above PERIOD, is ignored. The active width, `change_done` and `monitor_en` are all unaffected.
- R6: `active_width` changes only at a period boundary. Every complete high pulse on `pwm` lasts either the old width or the new width, never a partial one.
- R7: Every change of requested width restarts a settle window of SETTLE_CYCLES cycles, and its end raises a one-cycle `change_done` pulse. Timing is counted from the clock edge that samples the request: a hardware level change ends SETTLE_CYCLES edges later, and an accepted software request ends SETTLE_CYCLES+1 edges later.
- R8: `monitor_en` is low while a settle window runs. When a window started by a hardware change ends, `monitor_en` rises in the same cycle as `change_done`.
- R9: After a software-chosen width settles, `monitor_en` stays low until software strobes `tacho_period_we` and then `tacho_tol_we`. A tolerance strobe with no period strobe before it is ignored, and so is a period strobe made during the settle window.
- R10: In software mode, if the hardware width rises above the software width, the hardware width replaces it. A new settle window starts one cycle after the override, and at its end `monitor_en` returns without any tacho writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_duty | input | 3 | Hardware duty level code (0..4, higher codes mean full duty) |
| sw_width | input | W | Requested software width in cycles |
| sw_width_we | input | 1 | One-cycle strobe for `sw_width` |
| tacho_period_we | input | 1 | Software wrote a custom tacho period |
| tacho_tol_we | input | 1 | Software wrote a custom tacho tolerance |
| pwm | output | 1 | Fan PWM output |
| active_width | output | W | Width currently shaping the waveform |
| change_done | output | 1 | One-cycle pulse when a settle window ends |
| monitor_en | output | 1 | Tacho supervision enable |

## Verification
The bench aims at the edges of the acceptance window. A request one below the hardware width, or one above the period, must change nothing; a design with an off-by-one compare would switch width and raise `change_done`. It issues a width change mid-period and measures every high pulse around it; a design that loads the width immediately shows a pulse length that is neither the old nor the new width. It also restarts the settle window part-way through, writes the tacho tolerance before the period and writes the period during settling. A timer that does not restart, or an enable that ignores write order, would raise `change_done` early or set `monitor_en` too soon. Last, it raises the hardware level above a software width and checks that the hardware width takes over, which a design without the override would miss.

// File: rtl/fanpwm_pkg.sv
package fanpwm_pkg;

  typedef enum logic [2:0] {
    DUTY_OFF  = 3'd0,
    DUTY_Q1   = 3'd1,
    DUTY_HALF = 3'd2,
    DUTY_Q3   = 3'd3,
    DUTY_FULL = 3'd4
  } duty_code_e;

  // Width in cycles for a hardware duty code; codes above FULL saturate.
  function automatic int unsigned duty_width(logic [2:0] code, int unsigned period);
    case (code)
      DUTY_OFF:  return 0;
      DUTY_Q1:   return period / 4;
      DUTY_HALF: return period / 2;
      DUTY_Q3:   return (3 * period) / 4;
      default:   return period;
    endcase
  endfunction

endpackage

// File: rtl/fanpwm_sel.sv
module fanpwm_sel #(
  parameter int unsigned PERIOD = 20000,
  parameter int unsigned W      = $clog2(PERIOD + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   hw_duty,
  input  logic [W-1:0] sw_width,
  input  logic         sw_width_we,
  output logic [W-1:0] target,
  output logic         req,
  output logic         sw_mode
);

  localparam logic [W-1:0] FULL_W = W'(PERIOD);

  logic [W-1:0] hw_w;
  logic         accept, override;
  logic         mode_q, mode_d;
  logic [W-1:0] sww_q, sww_d;
  logic [W-1:0] tgt_q;
  logic         acc_q;

  assign hw_w     = W'(fanpwm_pkg::duty_width(hw_duty, PERIOD));
  assign accept   = sw_width_we && (sw_width >= hw_w) && (sw_width <= FULL_W);
  assign override = mode_q && (hw_w > sww_q);

  always_comb begin
    mode_d = mode_q;
    sww_d  = sww_q;
    if (accept) begin
      mode_d = 1'b1;
      sww_d  = sw_width;
    end else if (override) begin
      mode_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      sww_q  <= FULL_W;
      tgt_q  <= FULL_W;
      acc_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      sww_q  <= sww_d;
      tgt_q  <= target;
      acc_q  <= accept;
    end
  end

  assign target  = mode_q ? sww_q : hw_w;
  assign req     = (target != tgt_q) || acc_q;
  assign sw_mode = mode_q;

  AST_SW_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> (sww_q <= FULL_W)); // R4

  AST_HW_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && (hw_w > sww_q) && !sw_width_we) |=> !mode_q); // R10

endmodule

// File: rtl/fanpwm_wave.sv
module fanpwm_wave #(
  parameter int unsigned PERIOD = 20000,
  parameter int unsigned W      = $clog2(PERIOD + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] target,
  output logic [W-1:0] active_width,
  output logic         pwm
);

  localparam logic [W-1:0] LAST   = W'(PERIOD - 1);
  localparam logic [W-1:0] FULL_W = W'(PERIOD);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] act_q, act_d;
  logic         pwm_q, pwm_d;
  logic         wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    act_d = wrap ? target : act_q;
    pwm_d = (cnt_d < act_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= FULL_W;
      pwm_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      pwm_q <= pwm_d;
    end
  end

  assign active_width = act_q;
  assign pwm          = pwm_q;

  AST_WIDTH_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> ($past(cnt_q) == LAST)); // R6

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R2

endmodule

// File: rtl/fanpwm_settle.sv
module fanpwm_settle #(
  parameter int unsigned SETTLE_CYCLES = 500_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic sw_mode,
  input  logic tp_we,
  input  logic tol_we,
  output logic done,
  output logic mon_en
);

  localparam int unsigned TW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [TW-1:0] END_CNT = TW'(SETTLE_CYCLES - 1);

  logic          busy_q, busy_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          mon_q, mon_d;
  logic          need_q, need_d;
  logic          seen_q, seen_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    mon_d  = mon_q;
    need_d = need_q;
    seen_d = seen_q;
    if (req) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      mon_d  = 1'b0;
      need_d = sw_mode;
      seen_d = 1'b0;
    end else if (busy_q) begin
      if (cnt_q == END_CNT) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        mon_d  = !need_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (need_q) begin
      if (tol_we && seen_q) begin
        mon_d  = 1'b1;
        need_d = 1'b0;
        seen_d = 1'b0;
      end else if (tp_we) begin
        seen_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      done_q <= 1'b0;
      mon_q  <= 1'b0;
      need_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      mon_q  <= mon_d;
      need_q <= need_d;
      seen_q <= seen_d;
    end
  end

  assign done   = done_q;
  assign mon_en = mon_q;

  AST_MON_OFF_WHILE_SETTLING: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !mon_q); // R8

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7

  AST_SETTLE_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= END_CNT); // R7

  AST_TOL_NEEDS_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && need_q && !seen_q && !req) |=> !mon_q); // R9

endmodule

// File: rtl/fanpwm_core.sv
module fanpwm_core #(
  parameter int unsigned PERIOD        = 20000,
  parameter int unsigned SETTLE_CYCLES = 500_000_000,
  localparam int unsigned W            = $clog2(PERIOD + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   hw_duty,
  input  logic [W-1:0] sw_width,
  input  logic         sw_width_we,
  input  logic         tacho_period_we,
  input  logic         tacho_tol_we,
  output logic         pwm,
  output logic [W-1:0] active_width,
  output logic         change_done,
  output logic         monitor_en
);

  logic [W-1:0] target;
  logic         req;
  logic         sw_mode;

  fanpwm_sel #(.PERIOD(PERIOD), .W(W)) u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_duty     (hw_duty),
    .sw_width    (sw_width),
    .sw_width_we (sw_width_we),
    .target      (target),
    .req         (req),
    .sw_mode     (sw_mode)
  );

  fanpwm_wave #(.PERIOD(PERIOD), .W(W)) u_wave (
    .clk          (clk),
    .rst_n        (rst_n),
    .target       (target),
    .active_width (active_width),
    .pwm          (pwm)
  );

  fanpwm_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .sw_mode (sw_mode),
    .tp_we   (tacho_period_we),
    .tol_we  (tacho_tol_we),
    .done    (change_done),
    .mon_en  (monitor_en)
  );

endmodule

// File: tb/tb_fanpwm_core.sv
module tb_fanpwm_core;

  localparam int unsigned P = 20;
  localparam int unsigned S = 60;
  localparam int unsigned W = $clog2(P + 1);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   hw_duty = 3'd4;
  logic [W-1:0] sw_width = '0;
  logic         sw_width_we = 1'b0;
  logic         tacho_period_we = 1'b0;
  logic         tacho_tol_we = 1'b0;
  logic         pwm;
  logic [W-1:0] active_width;
  logic         change_done;
  logic         monitor_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  fanpwm_core #(.PERIOD(P), .SETTLE_CYCLES(S)) dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .hw_duty         (hw_duty),
    .sw_width        (sw_width),
    .sw_width_we     (sw_width_we),
    .tacho_period_we (tacho_period_we),
    .tacho_tol_we    (tacho_tol_we),
    .pwm             (pwm),
    .active_width    (active_width),
    .change_done     (change_done),
    .monitor_en      (monitor_en)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      summary();
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_done(output int n);
    n = 0;
    for (int i = 1; i <= 4 * S; i++) begin
      @(negedge clk);
      if (change_done) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic measure_high(output int h);
    h = 0;
    repeat (P) begin
      @(negedge clk);
      if (pwm) h++;
    end
  endtask

  task automatic set_duty(logic [2:0] d);
    @(negedge clk);
    hw_duty = d;
  endtask

  task automatic sw_req(int v);
    @(negedge clk);
    sw_width = W'(v);
    sw_width_we = 1'b1;
    @(negedge clk);
    sw_width_we = 1'b0;
  endtask

  task automatic pulse_period();
    @(negedge clk);
    tacho_period_we = 1'b1;
    @(negedge clk);
    tacho_period_we = 1'b0;
  endtask

  task automatic pulse_tol();
    @(negedge clk);
    tacho_tol_we = 1'b1;
    @(negedge clk);
    tacho_tol_we = 1'b0;
  endtask

  task automatic test_reset();
    int n;
    int h;
    chk(active_width == W'(P), "R1 width in reset", int'(active_width), P);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(active_width == W'(P), "R1 width after reset", int'(active_width), P);
    chk(!monitor_en, "R1 monitor after reset", int'(monitor_en), 0);
    chk(!change_done, "R1 done after reset", int'(change_done), 0);
    measure_high(h);
    chk(h == P, "R3 full duty high", h, P);
    wait_done(n);
    chk(n != 0, "R1 reset settle ends", n, 1);
    chk(monitor_en, "R8 monitor after reset settle", int'(monitor_en), 1);
  endtask

  task automatic test_hw_levels();
    int n;
    int h;
    set_duty(3'd2);
    repeat (2) @(negedge clk);
    chk(!monitor_en, "R8 monitor off in settle", int'(monitor_en), 0);
    set_duty(3'd2);
    wait_done(n);
    chk(n == S - 2, "R7 hw settle length", n, S - 2);
    chk(monitor_en, "R8 monitor with done", int'(monitor_en), 1);
    chk(active_width == W'(P / 2), "R2 active half", int'(active_width), P / 2);
    measure_high(h);
    chk(h == P / 2, "R2 half high count", h, P / 2);

    set_duty(3'd1);
    wait_done(n);
    measure_high(h);
    chk(h == P / 4, "R2 quarter high count", h, P / 4);

    set_duty(3'd3);
    wait_done(n);
    measure_high(h);
    chk(h == (3 * P) / 4, "R2 three quarter high count", h, (3 * P) / 4);

    set_duty(3'd0);
    wait_done(n);
    measure_high(h);
    chk(h == 0, "R3 off duty high count", h, 0);

    set_duty(3'd6);
    wait_done(n);
    measure_high(h);
    chk(h == P, "R2 code 6 saturates", h, P);
  endtask

  task automatic test_restart();
    int n;
    set_duty(3'd1);
    repeat (20) @(negedge clk);
    set_duty(3'd2);
    wait_done(n);
    chk(n == S + 1, "R7 restart settle length", n, S + 1);
  endtask

  task automatic test_reject();
    int n;
    sw_req(P / 2 - 1);
    wait_done(n);
    chk(n == 0, "R5 low request no done", n, 0);
    chk(active_width == W'(P / 2), "R5 low request width", int'(active_width), P / 2);
    chk(monitor_en, "R5 low request monitor", int'(monitor_en), 1);
    sw_req(P + 1);
    wait_done(n);
    chk(n == 0, "R5 high request no done", n, 0);
    chk(active_width == W'(P / 2), "R5 high request width", int'(active_width), P / 2);
  endtask

  task automatic test_boundary_accept();
    int cur;
    int runs;
    int bad;
    int done_at;
    int mon_at;
    while (pwm) @(negedge clk);
    while (!pwm) @(negedge clk);
    cur = 1;
    runs = 0;
    bad = 0;
    done_at = 0;
    mon_at = 0;
    for (int i = 1; i <= 4 * P; i++) begin
      if (i == 1) begin
        sw_width = W'(13);
        sw_width_we = 1'b1;
      end else if (i == 2) begin
        sw_width_we = 1'b0;
      end
      @(negedge clk);
      if (change_done && done_at == 0) begin
        done_at = i;
        mon_at = int'(monitor_en);
      end
      if (pwm) cur++;
      else if (cur > 0) begin
        runs++;
        if (cur != P / 2 && cur != 13) bad = cur;
        cur = 0;
      end
    end
    chk(bad == 0, "R6 no runt pulse", bad, 13);
    chk(runs >= 3, "R6 pulses seen", runs, 3);
    chk(active_width == W'(13), "R4 accepted width", int'(active_width), 13);
    chk(done_at == S + 2, "R7 sw settle length", done_at, S + 2);
    chk(mon_at == 0, "R9 monitor off after sw settle", mon_at, 0);
  endtask

  task automatic test_tacho_order();
    int n;
    pulse_tol();
    @(negedge clk);
    chk(!monitor_en, "R9 tolerance alone ignored", int'(monitor_en), 0);
    pulse_period();
    @(negedge clk);
    chk(!monitor_en, "R9 period alone", int'(monitor_en), 0);
    pulse_tol();
    @(negedge clk);
    chk(monitor_en, "R9 period then tolerance", int'(monitor_en), 1);

    sw_req(14);
    pulse_period();
    wait_done(n);
    pulse_tol();
    @(negedge clk);
    chk(!monitor_en, "R9 period in settle ignored", int'(monitor_en), 0);
    pulse_period();
    pulse_tol();
    @(negedge clk);
    chk(monitor_en, "R9 writes after settle", int'(monitor_en), 1);
  endtask

  task automatic test_override();
    int n;
    int h;
    set_duty(3'd3);
    wait_done(n);
    chk(n == S + 2, "R10 override settle length", n, S + 2);
    chk(monitor_en, "R10 monitor without writes", int'(monitor_en), 1);
    chk(active_width == W'(15), "R10 hw width takes over", int'(active_width), 15);
    measure_high(h);
    chk(h == 15, "R10 override high count", h, 15);

    sw_req(16);
    wait_done(n);
    pulse_period();
    pulse_tol();
    set_duty(3'd1);
    wait_done(n);
    chk(n == 0, "R4 lower hw no change", n, 0);
    chk(active_width == W'(16), "R4 sw width kept", int'(active_width), 16);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    test_hw_levels();
    test_restart();
    test_reject();
    test_boundary_accept();
    test_tacho_order();
    test_override();
    summary();
  end

endmodule